// File: doc/BRIEF.md
# Thermal Derating and Shutdown Controller

This block limits a 12-bit dim level according to two filtered 8-bit temperature codes. The slowly filtered code drives a proportional derating. Once that code rises past a programmable threshold, the requested dim level is lowered by a selectable number of dim steps for every code of excess. The lowered level never goes below zero.

The quickly filtered code drives a protective trip with hysteresis. When it reaches the trip code, the output is held at zero and a shutdown flag is raised. The flag stays up until the fast code falls back to the wakeup code. The trip code is not programmed directly. It is formed as the wakeup code plus four codes for each unit of a 4-bit offset field. For this to work, software keeps the configuration ordered as derating threshold below wakeup, and wakeup below trip.

The controller sits after the temperature filters and in front of the dimming stage. Both outputs are registered and are updated on every clock from the current inputs. Filtering of the codes is done elsewhere.

Top module: `thermal_derate_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dim_out` becomes 0 and `shutdown` becomes 0.
- R2: The trip code is `wake_code + 4*trip_offset`, saturating at 255. When `shutdown` is low and `fast_code` is at or above the trip code at a rising edge, `shutdown` is 1 after that edge. Otherwise, from the low state, `shutdown` stays 0.
- R3: When `shutdown` is high and `fast_code <= wake_code` at a rising edge, `shutdown` is 0 after that edge. While `fast_code > wake_code`, `shutdown` stays 1, even when the code sits between the wakeup and trip codes.
- R4: After any edge where `shutdown` is 1 after that edge, `dim_out` is 0. This includes the edge on which the trip is entered.
- R5: The derating threshold on the code scale is `derate_thr*8`, i.e. the 5-bit field shifted left by 3. When `slow_code` is at or below that value, `dim_out` equals `dim_req` one edge later, provided no trip is present.
- R6: When `slow_code` is above the threshold, the removed amount is `(4 << rate_sel) * (slow_code - derate_thr*8)`. The 2-bit codes 0, 1, 2 and 3 select 4, 8, 16 and 32 steps per code. `dim_out` is `dim_req` minus that amount, registered with one edge of latency.
- R7: When the removed amount is at or above `dim_req`, `dim_out` is 0. It never wraps.
- R8: `slow_code` has no effect on `shutdown`, and `fast_code` has no effect on the derated level when no trip is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fast_code | input | 8 | Quickly filtered temperature code, used for trip |
| slow_code | input | 8 | Slowly filtered temperature code, used for derating |
| dim_req | input | 12 | Requested dim level |
| derate_thr | input | 5 | Derating threshold, compared as value times 8 |
| wake_code | input | 8 | Code at or below which a trip is released |
| trip_offset | input | 4 | Trip code offset above wakeup, in units of 4 codes |
| rate_sel | input | 2 | Derating slope: 4, 8, 16 or 32 steps per code |
| dim_out | output | 12 | Limited dim level |
| shutdown | output | 1 | Trip flag, high while the output is forced off |

## Verification
Directed steps walk `slow_code` across the threshold one code at a time and then far above it under the steepest slope. This separates the exact edge of the comparison, the per-code slope and the floor at zero. A ramp of `fast_code` through one below, at, between and at the wakeup code shows set-on-reach, hold in the hysteresis band and release. A wakeup code near the top with the largest offset exposes any wrap of the trip code instead of saturation. Long runs with randomized configuration and codes are compared on every clock against a behavioural model. These mix both codes independently, so a design that crosses the slow and fast paths, or drops the same-edge output blanking, diverges.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

    localparam int CODE_W          = 8;
    localparam int DIM_W           = 12;
    localparam int THR_W           = 5;
    localparam int OFF_W           = 4;
    localparam int RATE_W          = 2;

    localparam int THR_SHIFT       = CODE_W - THR_W;
    localparam int OFF_SHIFT       = 2;
    localparam int RATE_BASE_SHIFT = 2;
    localparam int NUM_RATES       = 1 << RATE_W;
    localparam int STEP_W          = CODE_W + RATE_BASE_SHIFT + NUM_RATES - 1;
    localparam int CMP_W           = (STEP_W > DIM_W) ? STEP_W : DIM_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DIM_W-1:0]  dim_t;

    localparam code_t CODE_MAX = '1;

    typedef struct packed {
        logic [THR_W-1:0]  thr;
        code_t             wake;
        logic [OFF_W-1:0]  off;
        logic [RATE_W-1:0] rate;
    } therm_cfg_t;

    typedef enum logic {
        THERM_RUN  = 1'b0,
        THERM_TRIP = 1'b1
    } therm_state_e;

    function automatic code_t trip_code_of(code_t wake, logic [OFF_W-1:0] off);
        logic [CODE_W:0] sum;
        logic [CODE_W:0] add;
        add = {{(CODE_W + 1 - OFF_W){1'b0}}, off} << OFF_SHIFT;
        sum = {1'b0, wake} + add;
        return sum[CODE_W] ? CODE_MAX : sum[CODE_W-1:0];
    endfunction

    function automatic code_t thr_to_code(logic [THR_W-1:0] thr);
        return {thr, {THR_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/therm_trip_fsm.sv
module therm_trip_fsm
    import thermal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  code_t            fast_code,
    input  code_t            wake_code,
    input  logic [OFF_W-1:0] trip_offset,
    output logic             trip_next,
    output logic             tripped
);

    therm_state_e state_q, state_d;
    code_t        trip_code;

    assign trip_code = trip_code_of(wake_code, trip_offset);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THERM_RUN:  if (fast_code >= trip_code) state_d = THERM_TRIP;
            THERM_TRIP: if (fast_code <= wake_code) state_d = THERM_RUN;
            default:    state_d = THERM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= THERM_RUN;
        else     state_q <= state_d;
    end

    assign trip_next = (state_d == THERM_TRIP);
    assign tripped   = (state_q == THERM_TRIP);

    // R2: reaching the trip code from the running state raises the flag
    p_trip_set_r2: assert property (@(posedge clk) disable iff (rst)
        (!tripped && fast_code >= trip_code) |=> tripped);

    // R2: below the trip code the flag stays low
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tripped && fast_code < trip_code) |=> !tripped);

    // R2: the trip code never wraps below the wakeup code
    p_trip_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        trip_code >= wake_code);

    // R3: falling to the wakeup code releases the trip
    p_trip_release_r3: assert property (@(posedge clk) disable iff (rst)
        (tripped && fast_code <= wake_code) |=> !tripped);

    // R3: hysteresis band keeps the trip active
    p_trip_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (tripped && fast_code > wake_code) |=> tripped);

endmodule

// File: rtl/therm_derate.sv
module therm_derate
    import thermal_pkg::*;
(
    input  code_t             slow_code,
    input  dim_t              dim_req,
    input  logic [THR_W-1:0]  derate_thr,
    input  logic [RATE_W-1:0] rate_sel,
    output dim_t              dim_lim
);

    code_t             thr_code;
    code_t             excess;
    logic [STEP_W-1:0] step_opt [NUM_RATES];
    logic [STEP_W-1:0] steps;
    logic [CMP_W-1:0]  req_ext;
    logic [CMP_W-1:0]  steps_ext;
    logic [CMP_W-1:0]  diff;

    assign thr_code = thr_to_code(derate_thr);
    assign excess   = (slow_code > thr_code) ? (slow_code - thr_code) : '0;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign step_opt[g] = STEP_W'(excess) << (RATE_BASE_SHIFT + g);
    end

    assign steps     = step_opt[rate_sel];
    assign req_ext   = CMP_W'(dim_req);
    assign steps_ext = CMP_W'(steps);
    assign diff      = req_ext - steps_ext;

    always_comb begin
        if (steps_ext >= req_ext) dim_lim = '0;
        else                      dim_lim = diff[DIM_W-1:0];
    end

endmodule

// File: rtl/thermal_derate_top.sv
module thermal_derate_top
    import thermal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  fast_code,
    input  logic [7:0]  slow_code,
    input  logic [11:0] dim_req,
    input  logic [4:0]  derate_thr,
    input  logic [7:0]  wake_code,
    input  logic [3:0]  trip_offset,
    input  logic [1:0]  rate_sel,
    output logic [11:0] dim_out,
    output logic        shutdown
);

    therm_cfg_t cfg;
    dim_t       dim_lim;
    logic       trip_next;
    logic       tripped;
    dim_t       dim_q;
    logic       past_ok;

    assign cfg.thr  = derate_thr;
    assign cfg.wake = wake_code;
    assign cfg.off  = trip_offset;
    assign cfg.rate = rate_sel;

    therm_trip_fsm u_trip (
        .clk         (clk),
        .rst         (rst),
        .fast_code   (fast_code),
        .wake_code   (cfg.wake),
        .trip_offset (cfg.off),
        .trip_next   (trip_next),
        .tripped     (tripped)
    );

    therm_derate u_derate (
        .slow_code  (slow_code),
        .dim_req    (dim_req),
        .derate_thr (cfg.thr),
        .rate_sel   (cfg.rate),
        .dim_lim    (dim_lim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dim_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            dim_q   <= trip_next ? '0 : dim_lim;
            past_ok <= 1'b1;
        end
    end

    assign dim_out  = dim_q;
    assign shutdown = tripped;

    // R4: output forced off whenever the trip flag is up
    p_off_while_tripped_r4: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (dim_out == '0));

    // R5: no reduction at or below the threshold
    p_pass_when_cool_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !shutdown && $past(slow_code <= thr_to_code(derate_thr)))
        |-> (dim_out == $past(dim_req)));

    // R6, R7: the limited level never exceeds the request
    p_not_above_req_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (dim_out <= $past(dim_req)));

endmodule

// File: tb/tb_thermal_derate_top.sv
module tb_thermal_derate_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  fast_code = '0;
    logic [7:0]  slow_code = '0;
    logic [11:0] dim_req = '0;
    logic [4:0]  derate_thr = '0;
    logic [7:0]  wake_code = '0;
    logic [3:0]  trip_offset = '0;
    logic [1:0]  rate_sel = '0;
    logic [11:0] dim_out;
    logic        shutdown;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    int    m_flag = 0;
    int    m_dim  = 0;
    string m_tag  = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    thermal_derate_top dut (
        .clk         (clk),
        .rst         (rst),
        .fast_code   (fast_code),
        .slow_code   (slow_code),
        .dim_req     (dim_req),
        .derate_thr  (derate_thr),
        .wake_code   (wake_code),
        .trip_offset (trip_offset),
        .rate_sel    (rate_sel),
        .dim_out     (dim_out),
        .shutdown    (shutdown)
    );

    always @(posedge clk) begin
        int sd, thr8, ex, st, d;
        if (rst) begin
            m_flag = 0;
            m_dim  = 0;
            m_tag  = "R1";
        end else begin
            sd = int'(wake_code) + 4 * int'(trip_offset);
            if (sd > 255) sd = 255;
            if (m_flag == 0 && int'(fast_code) >= sd) m_flag = 1;
            else if (m_flag == 1 && int'(fast_code) <= int'(wake_code)) m_flag = 0;
            thr8 = int'(derate_thr) * 8;
            ex   = (int'(slow_code) > thr8) ? int'(slow_code) - thr8 : 0;
            st   = ex * (4 << rate_sel);
            d    = (int'(dim_req) > st) ? int'(dim_req) - st : 0;
            m_dim = (m_flag != 0) ? 0 : d;
            if (m_flag != 0)  m_tag = "R4";
            else if (ex == 0) m_tag = "R5";
            else if (d == 0)  m_tag = "R7";
            else              m_tag = "R6";
        end
    end

    task automatic compare(string tag);
        string dtag, ftag;
        dtag = (tag == "") ? m_tag : tag;
        ftag = (tag == "") ? ((m_flag != 0) ? "R2" : "R3") : tag;
        n_tests++;
        if (int'(shutdown) != m_flag) begin
            n_fail++;
            $display("FAIL %s shutdown: actual %0d expected %0d", ftag, shutdown, m_flag);
        end
        n_tests++;
        if (int'(dim_out) != m_dim) begin
            n_fail++;
            $display("FAIL %s dim_out: actual %0d expected %0d", dtag, dim_out, m_dim);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_cfg(int thr, int wake, int off, int rate);
        derate_thr  = 5'(thr);
        wake_code   = 8'(wake);
        trip_offset = 4'(off);
        rate_sel    = 2'(rate);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with non-zero inputs applied
        dim_req = 12'd900;
        slow_code = 8'd10;
        set_cfg(10, 120, 5, 0);
        cyc("R1");
        cyc("R1");
        rst = 1'b0;

        // R5: at threshold (80) no reduction
        dim_req = 12'd1000; slow_code = 8'd80; fast_code = 8'd20;
        cyc("R5");
        // R6: one code above, 4 per code
        slow_code = 8'd81;
        cyc("R6");
        // R6: rate 3, ten codes above -> 320 removed
        rate_sel = 2'd3; slow_code = 8'd90;
        cyc("R6");
        rate_sel = 2'd1; slow_code = 8'd100;
        cyc("R6");
        // R7: floor at zero
        rate_sel = 2'd3; slow_code = 8'd255;
        cyc("R7");
        dim_req = 12'd4095;
        cyc("R7");
        // R8: high fast code below trip leaves derating unchanged
        rate_sel = 2'd0; slow_code = 8'd85; dim_req = 12'd2000; fast_code = 8'd139;
        cyc("R8");
        // R2: trip code is 140
        fast_code = 8'd140;
        cyc("R2");
        // R4: output held off, slow code cool
        slow_code = 8'd0;
        cyc("R4");
        // R3: hysteresis band holds trip
        fast_code = 8'd130;
        cyc("R3");
        fast_code = 8'd121;
        cyc("R3");
        // R3: release at wakeup
        fast_code = 8'd120;
        cyc("R3");
        // R8: slow code far above threshold does not trip
        slow_code = 8'd255; fast_code = 8'd50;
        cyc("R8");
        // R2: trip code saturation (250 + 60 -> 255)
        set_cfg(4, 250, 15, 2);
        fast_code = 8'd254; slow_code = 8'd30; dim_req = 12'd3000;
        cyc("R2");
        fast_code = 8'd255;
        cyc("R2");
        fast_code = 8'd250;
        cyc("R3");
        // R1: mid-run reset clears trip and output
        fast_code = 8'd255;
        cyc("R2");
        rst = 1'b1;
        cyc("R1");
        rst = 1'b0;
        fast_code = 8'd0;

        // randomized mix, compared every clock
        for (int i = 0; i < 3000; i++) begin
            if (i % 40 == 0) begin
                int thr, wake, off;
                thr  = $urandom_range(0, 20);
                wake = thr * 8 + $urandom_range(1, 60);
                off  = $urandom_range(1, 15);
                set_cfg(thr, wake, off, $urandom_range(0, 3));
            end
            fast_code = 8'($urandom_range(0, 255));
            slow_code = 8'($urandom_range(0, 255));
            dim_req   = 12'($urandom_range(0, 4095));
            cyc("");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule